// File: doc/BRIEF.md
# Flag-Setting ALU with Condition Evaluator

This block is the integer execute stage of a 32-bit RISC data path. On each cycle with a valid strobe it combines two operands under a 4-bit opcode and returns the result one clock later. The operations are add, add-with-carry, subtract, subtract-with-carry, reverse subtract and six bitwise or move operations. It holds a four-bit flag register (negative, zero, carry, overflow). That register is written only when the operation asks for it.

Every subtraction is done by one adder, which adds the inverted second operand plus a carry-in. A set carry flag therefore means "no borrow". Bitwise operations do not compute a carry of their own. They take the carry bit delivered by an external shifter and leave the overflow flag as it was.

A separate 4-bit condition input is compared against the stored flags. The result is a pass signal that tells the issue logic whether the current instruction should execute. This signal uses the flags as they stand before the present operation commits.

Top module: `nzcv_alu`

## Requirements
- R1: Opcode 0 (ADD) produces op_a + op_b modulo 2^32. Opcode 1 (ADC) adds the stored C flag as well, so ADC 1,1 with C=1 gives 3.
- R2: For ADD, ADC, SUB, SBC and RSB, C is the carry out of bit 31. V is set when the two adder inputs share a sign and the sum's sign differs. Examples: 0xFFFFFFFF+1 gives 0 with flags NZCV=0110, and 0x7FFFFFFF+1 gives 0x80000000 with NZCV=1001.
- R3: Opcode 2 (SUB) computes op_a + ~op_b + 1. Opcode 3 (SBC) uses the stored C in place of the 1. Opcode 4 (RSB) computes op_b + ~op_a + 1. C set means no borrow, so SUB 0,1 gives 0xFFFFFFFF with C=0, and SUB 5,3 gives 2 with C=1.
- R4: Opcodes 5 AND, 6 EOR, 7 ORR, 8 BIC (op_a & ~op_b), 9 MOV (op_b) and 10 MVN (~op_b) produce the matching bitwise result.
- R5: For opcodes 5 to 10, C takes shift_carry and V keeps its previous value.
- R6: The flag register (flags[3]=N, [2]=Z, [1]=C, [0]=V) is written at a clock edge only when in_valid and set_flags are both high and the opcode is 0 to 10. Opcodes 11 to 15 never write flags and yield result 0.
- R7: On a flag write, N equals result bit 31 and Z is set exactly when the result is zero.
- R8: cond codes 0 to 14 pass when, in order: Z; !Z; C; !C; N; !N; V; !V; C&!Z; !C|Z; N==V; N!=V; !Z&(N==V); Z|(N!=V); always.
- R9: cond code 15 never passes.
- R10: cond_pass is combinational from the stored flags. During a cycle that will write new flags, it still reflects the old ones.
- R11: Synchronous active-high reset clears the flags, out_valid and out_result to zero.
- R12: out_valid follows in_valid by one clock, and out_result carries that operation's result whether or not set_flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 4 | Operation select (encoding in R1 to R4) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted |
| shift_carry | input | 1 | Carry out of the external shifter |
| set_flags | input | 1 | Commit flags for this operation |
| cond | input | 4 | Condition code to evaluate |
| cond_pass | output | 1 | Condition holds on stored flags |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 32 | Registered result |
| flags | output | 4 | Stored N, Z, C, V (bits 3 to 0) |

## Verification
The assertions assume that in_valid, opcode, set_flags and shift_carry are known values on every clock edge after reset. The flag-consistency checks also assume that a flag write is always accompanied by a valid result register update. The bench holds every input at a defined level from time zero and changes inputs only on the falling edge. It returns in_valid to zero between operations, so each operation is checked in isolation. It reaches the reachable flag combinations only through legal operations: an add sets V, then a move sets N, Z and C.

// File: rtl/nzcv_alu_pkg.sv
package nzcv_alu_pkg;
  localparam int OPC_W  = 4;
  localparam int COND_W = 4;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'd0;
  localparam logic [OPC_W-1:0] OPC_ADC = 4'd1;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'd2;
  localparam logic [OPC_W-1:0] OPC_SBC = 4'd3;
  localparam logic [OPC_W-1:0] OPC_RSB = 4'd4;
  localparam logic [OPC_W-1:0] OPC_AND = 4'd5;
  localparam logic [OPC_W-1:0] OPC_EOR = 4'd6;
  localparam logic [OPC_W-1:0] OPC_ORR = 4'd7;
  localparam logic [OPC_W-1:0] OPC_BIC = 4'd8;
  localparam logic [OPC_W-1:0] OPC_MOV = 4'd9;
  localparam logic [OPC_W-1:0] OPC_MVN = 4'd10;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/nzcv_adder.sv
module nzcv_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
    sum  = wide[MSB:0];
    cout = wide[DATA_W];
    ovf  = (x[MSB] ~^ y[MSB]) & (sum[MSB] ^ x[MSB]);
  end
endmodule

// File: rtl/nzcv_logic_unit.sv
module nzcv_logic_unit
  import nzcv_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OPC_W-1:0]  sel,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (sel)
      OPC_AND: res = x & y;
      OPC_EOR: res = x ^ y;
      OPC_ORR: res = x | y;
      OPC_BIC: res = x & ~y;
      OPC_MOV: res = y;
      OPC_MVN: res = ~y;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/nzcv_cond_eval.sv
module nzcv_cond_eval
  import nzcv_alu_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  nzcv_t             f,
  output logic              pass
);
  logic ge;

  always_comb begin
    ge = (f.n == f.v);
    unique case (cond)
      4'd0:    pass = f.z;
      4'd1:    pass = !f.z;
      4'd2:    pass = f.c;
      4'd3:    pass = !f.c;
      4'd4:    pass = f.n;
      4'd5:    pass = !f.n;
      4'd6:    pass = f.v;
      4'd7:    pass = !f.v;
      4'd8:    pass = f.c && !f.z;
      4'd9:    pass = !f.c || f.z;
      4'd10:   pass = ge;
      4'd11:   pass = !ge;
      4'd12:   pass = !f.z && ge;
      4'd13:   pass = f.z || !ge;
      4'd14:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/nzcv_alu.sv
module nzcv_alu
  import nzcv_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        opcode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              shift_carry,
  input  logic              set_flags,
  input  logic [3:0]        cond,
  output logic              cond_pass,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [3:0]        flags
);
  localparam int MSB = DATA_W - 1;

  nzcv_t flags_q;
  nzcv_t flags_d;

  logic              is_arith;
  logic              is_logic;
  logic [DATA_W-1:0] add_x;
  logic [DATA_W-1:0] add_y;
  logic              add_cin;
  logic [DATA_W-1:0] add_sum;
  logic              add_cout;
  logic              add_ovf;
  logic [DATA_W-1:0] log_res;
  logic [DATA_W-1:0] result;

  // decode and operand steering into the single adder
  always_comb begin
    is_arith = (opcode <= OPC_RSB);
    is_logic = (opcode >= OPC_AND) && (opcode <= OPC_MVN);
    add_x    = op_a;
    add_y    = op_b;
    add_cin  = 1'b0;
    unique case (opcode)
      OPC_ADD: add_cin = 1'b0;
      OPC_ADC: add_cin = flags_q.c;
      OPC_SUB: begin add_y = ~op_b; add_cin = 1'b1;      end
      OPC_SBC: begin add_y = ~op_b; add_cin = flags_q.c; end
      OPC_RSB: begin add_x = op_b; add_y = ~op_a; add_cin = 1'b1; end
      default: add_cin = 1'b0;
    endcase
  end

  nzcv_adder #(.DATA_W(DATA_W)) u_add (
    .x    (add_x),
    .y    (add_y),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  nzcv_logic_unit #(.DATA_W(DATA_W)) u_log (
    .sel (opcode),
    .x   (op_a),
    .y   (op_b),
    .res (log_res)
  );

  always_comb begin
    if (is_arith)      result = add_sum;
    else if (is_logic) result = log_res;
    else               result = '0;
    flags_d.n = result[MSB];
    flags_d.z = (result == '0);
    flags_d.c = is_arith ? add_cout : shift_carry;
    flags_d.v = is_arith ? add_ovf  : flags_q.v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q    <= '0;
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= result;
      if (in_valid && set_flags && (is_arith || is_logic)) flags_q <= flags_d;
    end
  end

  nzcv_cond_eval u_cond (
    .cond (cond),
    .f    (flags_q),
    .pass (cond_pass)
  );

  assign flags = flags_q;
endmodule

// File: rtl/nzcv_alu_checker.sv
module nzcv_alu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        opcode,
  input logic              shift_carry,
  input logic              set_flags,
  input logic [3:0]        cond,
  input logic              cond_pass,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic [3:0]        flags
);
  logic legal_wr;
  logic logic_wr;
  assign legal_wr = in_valid && set_flags && (opcode <= 4'd10);
  assign logic_wr = in_valid && set_flags && (opcode >= 4'd5) && (opcode <= 4'd10);

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (flags == 4'd0) && !out_valid && (out_result == '0));

  a_r6_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !legal_wr |=> $stable(flags));

  a_r7_n_z_match: assert property (@(posedge clk) disable iff (rst)
    legal_wr |=> (flags[3] == out_result[DATA_W-1]) && (flags[2] == (out_result == '0)));

  a_r5_keep_v: assert property (@(posedge clk) disable iff (rst)
    logic_wr |=> flags[0] == $past(flags[0]));

  a_r5_shift_c: assert property (@(posedge clk) disable iff (rst)
    logic_wr |=> flags[1] == $past(shift_carry));

  a_r9_never: assert property (@(posedge clk) disable iff (rst)
    (cond == 4'd15) |-> !cond_pass);

  a_r8_always: assert property (@(posedge clk) disable iff (rst)
    (cond == 4'd14) |-> cond_pass);

  a_r12_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r12_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
endmodule

bind nzcv_alu nzcv_alu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .opcode      (opcode),
  .shift_carry (shift_carry),
  .set_flags   (set_flags),
  .cond        (cond),
  .cond_pass   (cond_pass),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .flags       (flags)
);

// File: tb/nzcv_alu_test.sv
module nzcv_alu_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   opcode = 4'd0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         shift_carry = 1'b0;
  logic         set_flags = 1'b0;
  logic [3:0]   cond = 4'd14;
  logic         cond_pass;
  logic         out_valid;
  logic [W-1:0] out_result;
  logic [3:0]   flags;

  int nvec = 0;
  int nbad = 0;
  logic [3:0] mflags = 4'd0;

  always #4 clk = ~clk;

  nzcv_alu #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .shift_carry(shift_carry), .set_flags(set_flags),
    .cond(cond), .cond_pass(cond_pass), .out_valid(out_valid),
    .out_result(out_result), .flags(flags)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic cond_model(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0: return z;         4'd1: return !z;
      4'd2: return cy;        4'd3: return !cy;
      4'd4: return n;         4'd5: return !n;
      4'd6: return v;         4'd7: return !v;
      4'd8: return cy && !z;  4'd9: return !cy || z;
      4'd10: return n == v;   4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // reference model written from the requirements
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, output logic [31:0] r, output logic [3:0] nf,
                       output logic wr);
    logic [31:0] x, y;
    logic        ci;
    logic [32:0] w;
    longint      s;
    wr = 1'b1;
    x = a; y = b; ci = 1'b0;
    nf = mflags;
    if (op <= 4'd4) begin
      case (op)
        4'd1: ci = mflags[1];
        4'd2: begin y = ~b; ci = 1'b1; end
        4'd3: begin y = ~b; ci = mflags[1]; end
        4'd4: begin x = b; y = ~a; ci = 1'b1; end
        default: ci = 1'b0;
      endcase
      w = {1'b0, x} + {1'b0, y} + {32'd0, ci};
      r = w[31:0];
      s = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
      nf = {r[31], r == 32'd0, w[32], (s > 64'sd2147483647) || (s < -64'sd2147483648)};
    end else if (op <= 4'd10) begin
      case (op)
        4'd5: r = a & b;  4'd6: r = a ^ b;  4'd7: r = a | b;
        4'd8: r = a & ~b; 4'd9: r = b;      default: r = ~b;
      endcase
      nf = {r[31], r == 32'd0, sc, mflags[0]};
    end else begin
      r = 32'd0;
      wr = 1'b0;
    end
  endtask

  task automatic run_op(input string req, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic sc, input logic sf);
    logic [31:0] r;
    logic [3:0]  nf;
    logic        wr;
    model(op, a, b, sc, r, nf, wr);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; shift_carry = sc; set_flags = sf; in_valid = 1'b1;
    @(posedge clk); #1;
    if (sf && wr) mflags = nf;
    check({req, " result"}, 64'(out_result), 64'(r));
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " flags"}, 64'(flags), 64'(mflags));
    @(negedge clk);
    in_valid = 1'b0; set_flags = 1'b0;
  endtask

  task automatic force_flags(input logic [3:0] f);
    run_op("R2 setup", 4'd0, f[0] ? 32'h7FFF_FFFF : 32'd0, f[0] ? 32'd1 : 32'd0, 1'b0, 1'b1);
    run_op("R5 setup", 4'd9, 32'd0, f[3] ? 32'h8000_0000 : (f[2] ? 32'd0 : 32'd1), f[1], 1'b1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R11 flags", 64'(flags), 64'd0);
    check("R11 out_valid", 64'(out_valid), 64'd0);
    check("R11 out_result", 64'(out_result), 64'd0);
  endtask

  task automatic t_add;
    run_op("R2 carry", 4'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1);
    check("R2 carry nzcv", 64'(flags), 64'h6);
    run_op("R2 overflow", 4'd0, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b1);
    check("R2 overflow nzcv", 64'(flags), 64'h9);
    run_op("R1 add", 4'd0, 32'h1234_5678, 32'h0FED_CBA8, 1'b0, 1'b1);
    run_op("R2 neg ovf", 4'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1);
    run_op("R2 set c", 4'd0, 32'hFFFF_FFFF, 32'd2, 1'b0, 1'b1);
    run_op("R1 adc", 4'd1, 32'd1, 32'd1, 1'b0, 1'b0);
    check("R1 adc value", 64'(out_result), 64'd3);
  endtask

  task automatic t_sub;
    run_op("R3 sub", 4'd2, 32'd5, 32'd3, 1'b0, 1'b1);
    check("R3 sub no borrow", 64'(flags[1]), 64'd1);
    run_op("R3 borrow", 4'd2, 32'd0, 32'd1, 1'b0, 1'b1);
    check("R3 borrow value", 64'(out_result), 64'hFFFF_FFFF);
    check("R3 borrow c", 64'(flags[1]), 64'd0);
    run_op("R3 sbc", 4'd3, 32'd5, 32'd3, 1'b0, 1'b1);
    check("R3 sbc value", 64'(out_result), 64'd1);
    run_op("R3 rsb", 4'd4, 32'd3, 32'd10, 1'b0, 1'b1);
    check("R3 rsb value", 64'(out_result), 64'd7);
    run_op("R2 sub ovf", 4'd2, 32'h8000_0000, 32'd1, 1'b0, 1'b1);
  endtask

  task automatic t_logic;
    force_flags(4'b0001);
    run_op("R4 and", 4'd5, 32'hF0F0_1234, 32'hFF00_FF00, 1'b1, 1'b1);
    check("R5 v kept", 64'(flags[0]), 64'd1);
    run_op("R4 eor", 4'd6, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 1'b1);
    run_op("R4 orr", 4'd7, 32'h0000_00F0, 32'h0000_000F, 1'b1, 1'b1);
    run_op("R4 bic", 4'd8, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b1);
    run_op("R4 mov", 4'd9, 32'h1111_1111, 32'h8000_0000, 1'b1, 1'b1);
    check("R5 mov nzcv", 64'(flags), 64'hB);
    run_op("R7 zero", 4'd10, 32'd0, 32'hFFFF_FFFF, 1'b0, 1'b1);
    check("R7 zero nzcv", 64'(flags), 64'h5);
  endtask

  task automatic t_gate;
    force_flags(4'b0010);
    run_op("R6 no set", 4'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0);
    check("R12 result without set", 64'(out_result), 64'd0);
    check("R6 flags kept", 64'(flags), 64'h2);
    run_op("R6 reserved", 4'd12, 32'd7, 32'd9, 1'b1, 1'b1);
    check("R6 reserved flags", 64'(flags), 64'h2);
    @(negedge clk);
    opcode = 4'd0; op_a = 32'd0; op_b = 32'd0; set_flags = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1;
    check("R6 invalid flags", 64'(flags), 64'h2);
    check("R12 invalid out_valid", 64'(out_valid), 64'd0);
    @(negedge clk);
    set_flags = 1'b0;
  endtask

  task automatic t_cond;
    for (int f = 0; f < 16; f++) begin
      if (f[3] && f[2]) continue;
      force_flags(4'(f));
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        cond = 4'(c);
        #1;
        if (c == 15) check("R9 never", 64'(cond_pass), 64'd0);
        else check("R8 cond", 64'(cond_pass), 64'(cond_model(4'(c), 4'(f))));
      end
    end
    cond = 4'd14;
  endtask

  task automatic t_before_update;
    run_op("R10 setup", 4'd0, 32'd1, 32'd1, 1'b0, 1'b1);
    @(negedge clk);
    cond = 4'd0; opcode = 4'd0; op_a = 32'd0; op_b = 32'd0; set_flags = 1'b1; in_valid = 1'b1;
    #1;
    check("R10 old flags", 64'(cond_pass), 64'd0);
    @(posedge clk); #1;
    mflags = 4'h4;
    check("R10 new flags", 64'(cond_pass), 64'd1);
    @(negedge clk);
    in_valid = 1'b0; set_flags = 1'b0; cond = 4'd14;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_gate();
    t_cond();
    t_before_update();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nvec++;
    nbad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule